// File: doc/BRIEF.md
# Stereo ADC Digital Output Stage

This block sits between a pair of decimated audio ADC channels and the serial audio output. Each time a pair of 24-bit signed samples arrives with its valid strobe, the block applies four operations in a fixed order. First it gates off disabled ADC channels. Then it routes the two sources to the left and right outputs, inverts the polarity of selected outputs, and applies a per-channel digital gain in half-decibel steps. The result is saturated to 24 bits and presented one clock later with its own valid strobe.

Software reaches the block through a plain write port made of a strobe, an address and data. Volume codes are double-buffered. A write to a volume address only changes a holding register. The two active gains move together, in one cycle, whenever a volume write carries the commit bit. Both channels therefore change gain at the same sample.

The gain for a code X between 1 and 255 is 0.5·(X−195) dB, and code 0 mutes the channel. The gain is built as a power-of-two shift of the octave, taking 6 dB as one octave, multiplied by a semitone-style mantissa.

Top module: `adc_out_stage`

## Requirements
- R1: After a synchronous reset the outputs are zero and out_valid is low. Both ADC enables are off, the polarity and route fields are 00, and the holding and active volume codes are both 195 (0 dB).
- R2: Writes use three addresses. Address 0 is control: bit 0 enables the left ADC, bit 1 enables the right ADC, bits 3:2 select polarity and bits 5:4 select routing. Address 1 holds the left volume code and address 2 the right volume code, each in bits 7:0 with bit 8 as the commit bit. A write to address 3 changes nothing.
- R3: A disabled ADC channel contributes zero to every output it is routed to.
- R4: The route field works as follows. 00 sends the left ADC to the left output and the right ADC to the right output. 01 sends the left ADC to both outputs. 10 sends the right ADC to both outputs. 11 swaps the two channels.
- R5: The polarity field works as follows. 00 inverts nothing, 01 inverts the left output, 10 inverts the right output and 11 inverts both. Inversion is two's-complement negation, and −2^23 becomes 2^23−1.
- R6: A volume code X from 1 to 255 scales the sample by 2^q · M(k) / 32768. Here d = X−195, q = floor(d/12), k = d−12q, and M(k) = round(32768·2^(k/12)). The result is within ±1 LSB of the floor of that product.
- R7: Volume code 0 drives the channel output to zero.
- R8: A volume write with bit 8 clear loads only the holding register, and both active gains stay unchanged. A volume write with bit 8 set copies both holding codes, including the one just written, into both active gains in the same cycle.
- R9: Results beyond the signed 24-bit range are clamped to 8388607 or −8388608.
- R10: The outputs update, and out_valid is high, exactly one clock after a cycle with in_valid high. In all other cycles out_valid is low and the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 24 | Left ADC sample, signed |
| in_right | input | 24 | Right ADC sample, signed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 9 | Register write data |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |

## Verification
The assertions check a set of properties on every cycle:
- the one-cycle valid latency, and outputs that hold still between strobes;
- zero outputs while both ADCs are disabled;
- muting at code 0;
- active gains that stay put across writes without the commit bit and match both holding codes right after a commit;
- the reset state.

Only the bench scenarios can show the arithmetic itself. They cover the value of each gain code, each of the sixteen route and polarity combinations, clamping at both ends, and a disabled channel vanishing when it is routed to the other side.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;

   typedef struct packed {
      logic [1:0] route;
      logic [1:0] pol;
      logic       en_r;
      logic       en_l;
   } ctl_t;

   localparam int CTL_BITS  = 6;
   localparam int ADDR_CTL  = 0;
   localparam int ADDR_VOLL = 1;
   localparam int ADDR_VOLR = 2;

   // round(32768 * 2^(k/12)) for k = 0..11
   function automatic logic [15:0] semitone_mant(input logic [3:0] k);
      logic [15:0] m;
      case (k)
         4'd0:    m = 16'd32768;
         4'd1:    m = 16'd34716;
         4'd2:    m = 16'd36781;
         4'd3:    m = 16'd38968;
         4'd4:    m = 16'd41285;
         4'd5:    m = 16'd43740;
         4'd6:    m = 16'd46341;
         4'd7:    m = 16'd49097;
         4'd8:    m = 16'd52016;
         4'd9:    m = 16'd55109;
         4'd10:   m = 16'd58386;
         default: m = 16'd61858;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/adc_out_regs.sv
module adc_out_regs
   import adc_out_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int VOL_W     = 8,
   parameter int ZERO_CODE = 195
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [VOL_W:0]   wr_data,
   output ctl_t             ctl,
   output logic [VOL_W-1:0] hold_l,
   output logic [VOL_W-1:0] hold_r,
   output logic [VOL_W-1:0] act_l,
   output logic [VOL_W-1:0] act_r
);

   localparam logic [VOL_W-1:0] RST_CODE = VOL_W'(ZERO_CODE);

   logic             hit_ctl, hit_l, hit_r, commit;
   logic [VOL_W-1:0] hold_l_nx, hold_r_nx;

   always_comb begin
      hit_ctl   = wr_en && (wr_addr == ADDR_W'(ADDR_CTL));
      hit_l     = wr_en && (wr_addr == ADDR_W'(ADDR_VOLL));
      hit_r     = wr_en && (wr_addr == ADDR_W'(ADDR_VOLR));
      commit    = (hit_l || hit_r) && wr_data[VOL_W];
      hold_l_nx = hit_l ? wr_data[VOL_W-1:0] : hold_l;
      hold_r_nx = hit_r ? wr_data[VOL_W-1:0] : hold_r;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl    <= '0;
         hold_l <= RST_CODE;
         hold_r <= RST_CODE;
         act_l  <= RST_CODE;
         act_r  <= RST_CODE;
      end else begin
         if (hit_ctl) ctl <= ctl_t'(wr_data[CTL_BITS-1:0]);
         hold_l <= hold_l_nx;
         hold_r <= hold_r_nx;
         if (commit) begin
            act_l <= hold_l_nx;
            act_r <= hold_r_nx;
         end
      end
   end

endmodule

// File: rtl/adc_out_prep.sv
module adc_out_prep
   import adc_out_pkg::*;
#(
   parameter int DATA_W = 24
) (
   input  ctl_t                     ctl,
   input  logic signed [DATA_W-1:0] adc_l,
   input  logic signed [DATA_W-1:0] adc_r,
   output logic signed [DATA_W-1:0] pre_l,
   output logic signed [DATA_W-1:0] pre_r
);

   localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};

   logic signed [DATA_W-1:0] gated_l, gated_r;
   logic signed [DATA_W-1:0] pre [2];

   always_comb begin
      gated_l = ctl.en_l ? adc_l : '0;
      gated_r = ctl.en_r ? adc_r : '0;
   end

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      logic                     take_r;
      logic signed [DATA_W-1:0] routed;
      always_comb begin
         take_r = (ch == 0) ? ctl.route[1] : !ctl.route[0];
         routed = take_r ? gated_r : gated_l;
         if (!ctl.pol[ch])          pre[ch] = routed;
         else if (routed == NEG_LIM) pre[ch] = POS_LIM;
         else                       pre[ch] = -routed;
      end
   end

   assign pre_l = pre[0];
   assign pre_r = pre[1];

endmodule

// File: rtl/adc_out_gain.sv
module adc_out_gain
   import adc_out_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int VOL_W     = 8,
   parameter int MANT_W    = 16,
   parameter int STEPS     = 12,
   parameter int ZERO_CODE = 195,
   parameter bit ROUND_EN  = 1'b1
) (
   input  logic signed [DATA_W-1:0] smp,
   input  logic [VOL_W-1:0]         code,
   output logic signed [DATA_W-1:0] res
);

   localparam int FRAC   = MANT_W - 1;
   localparam int NOCT   = (ZERO_CODE + STEPS - 1) / STEPS;
   localparam int BIAS   = NOCT * STEPS - ZERO_CODE;
   localparam int SH_MAX = FRAC + NOCT;
   localparam int SH_W   = $clog2(SH_MAX + 1);
   localparam int IDX_W  = VOL_W + 1;
   localparam int PROD_W = DATA_W + MANT_W + 2;

   localparam logic signed [PROD_W-1:0] SAT_HI =
      {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [PROD_W-1:0] SAT_LO =
      {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   logic [IDX_W-1:0]         idx, oct_q, step_k;
   logic [SH_W-1:0]          sh;
   logic [MANT_W-1:0]        mant;
   logic signed [PROD_W-1:0] s_ext, m_ext, prod, biased, scaled;

   always_comb begin
      idx    = {1'b0, code} + IDX_W'(BIAS);
      oct_q  = idx / IDX_W'(STEPS);
      step_k = idx % IDX_W'(STEPS);
      sh     = SH_W'(SH_MAX) - SH_W'(oct_q);
      mant   = semitone_mant(step_k[3:0]);
      s_ext  = PROD_W'(smp);
      m_ext  = PROD_W'($signed({1'b0, mant}));
      prod   = s_ext * m_ext;
   end

   if (ROUND_EN) begin : g_round
      logic signed [PROD_W-1:0] half;
      always_comb begin
         half   = (PROD_W'(1) << sh) >>> 1;
         biased = prod + half;
      end
   end else begin : g_trunc
      always_comb biased = prod;
   end

   always_comb begin
      scaled = biased >>> sh;
      if (code == '0)           res = '0;
      else if (scaled > SAT_HI) res = SAT_HI[DATA_W-1:0];
      else if (scaled < SAT_LO) res = SAT_LO[DATA_W-1:0];
      else                      res = scaled[DATA_W-1:0];
   end

endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage
   import adc_out_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int VOL_W     = 8,
   parameter int ADDR_W    = 2,
   parameter int MANT_W    = 16,
   parameter int STEPS     = 12,
   parameter int ZERO_CODE = 195,
   parameter bit ROUND_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_left,
   input  logic signed [DATA_W-1:0] in_right,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [VOL_W:0]           wr_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_left,
   output logic signed [DATA_W-1:0] out_right
);

   localparam int NOCT  = (ZERO_CODE + STEPS - 1) / STEPS;
   localparam int Q_MAX = ((1 << VOL_W) - 1 + NOCT * STEPS - ZERO_CODE) / STEPS;

   if (DATA_W < 8)                    begin : g_bad_data  $error("DATA_W too small"); end
   if (VOL_W != 8)                    begin : g_bad_vol   $error("VOL_W must be 8"); end
   if (STEPS != 12 || MANT_W != 16)   begin : g_bad_table $error("mantissa table is 12 x 16 bit"); end
   if (ZERO_CODE < 1 || ZERO_CODE >= (1 << VOL_W))
                                      begin : g_bad_zero  $error("ZERO_CODE out of range"); end
   if (MANT_W - 1 + NOCT < Q_MAX)     begin : g_bad_shift $error("gain shift underflows"); end
   if (ADDR_W < 2)                    begin : g_bad_addr  $error("ADDR_W too small"); end
   if (VOL_W + 1 < CTL_BITS)          begin : g_bad_wd    $error("write data too narrow"); end

   ctl_t                     ctl;
   logic [VOL_W-1:0]         hold_l, hold_r, act_l, act_r;
   logic signed [DATA_W-1:0] pre_l, pre_r;
   logic signed [DATA_W-1:0] pre_v [2];
   logic signed [DATA_W-1:0] gain_v [2];
   logic [VOL_W-1:0]         code_v [2];

   adc_out_regs #(.ADDR_W(ADDR_W), .VOL_W(VOL_W), .ZERO_CODE(ZERO_CODE)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .ctl    (ctl),
      .hold_l (hold_l),
      .hold_r (hold_r),
      .act_l  (act_l),
      .act_r  (act_r)
   );

   adc_out_prep #(.DATA_W(DATA_W)) u_prep (
      .ctl  (ctl),
      .adc_l(in_left),
      .adc_r(in_right),
      .pre_l(pre_l),
      .pre_r(pre_r)
   );

   assign pre_v[0]  = pre_l;
   assign pre_v[1]  = pre_r;
   assign code_v[0] = act_l;
   assign code_v[1] = act_r;

   for (genvar ch = 0; ch < 2; ch++) begin : g_gain
      adc_out_gain #(
         .DATA_W(DATA_W), .VOL_W(VOL_W), .MANT_W(MANT_W), .STEPS(STEPS),
         .ZERO_CODE(ZERO_CODE), .ROUND_EN(ROUND_EN)
      ) u_gain (
         .smp (pre_v[ch]),
         .code(code_v[ch]),
         .res (gain_v[ch])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_left  <= '0;
         out_right <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_left  <= gain_v[0];
            out_right <= gain_v[1];
         end
      end
   end

endmodule

// File: rtl/adc_out_stage_chk.sv
module adc_out_stage_chk
   import adc_out_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int VOL_W     = 8,
   parameter int ADDR_W    = 2,
   parameter int ZERO_CODE = 195
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [VOL_W:0]           wr_data,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_left,
   input logic signed [DATA_W-1:0] out_right,
   input ctl_t                     ctl,
   input logic [VOL_W-1:0]         hold_l,
   input logic [VOL_W-1:0]         hold_r,
   input logic [VOL_W-1:0]         act_l,
   input logic [VOL_W-1:0]         act_r
);

   logic vol_wr, do_commit;
   assign vol_wr    = wr_en && (wr_addr == ADDR_W'(ADDR_VOLL) || wr_addr == ADDR_W'(ADDR_VOLR));
   assign do_commit = vol_wr && wr_data[VOL_W];

   // R1: reset state
   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (!out_valid && out_left == '0 && out_right == '0 &&
               act_l == VOL_W'(ZERO_CODE) && act_r == VOL_W'(ZERO_CODE)));

   // R10: valid follows input strobe by one clock
   p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

   // R3: both ADCs off gives silence
   p_disabled_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ctl.en_l && !ctl.en_r) |=> (out_left == '0 && out_right == '0));

   // R7: mute code
   p_mute_left_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && act_l == '0) |=> out_left == '0);
   p_mute_right_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && act_r == '0) |=> out_right == '0);

   // R8: no gain change without commit, pair commit otherwise
   p_no_commit_r8: assert property (@(posedge clk) disable iff (rst)
      !do_commit |=> ($stable(act_l) && $stable(act_r)));
   p_pair_commit_r8: assert property (@(posedge clk) disable iff (rst)
      do_commit |=> (act_l == hold_l && act_r == hold_r));

endmodule

bind adc_out_stage adc_out_stage_chk #(
   .DATA_W(DATA_W), .VOL_W(VOL_W), .ADDR_W(ADDR_W), .ZERO_CODE(ZERO_CODE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .out_valid(out_valid),
   .out_left (out_left),
   .out_right(out_right),
   .ctl      (ctl),
   .hold_l   (hold_l),
   .hold_r   (hold_r),
   .act_l    (act_l),
   .act_r    (act_r)
);

// File: tb/adc_out_stage_tb.sv
module adc_out_stage_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W = 24;
   localparam longint POS_MAX = (64'sd1 <<< (W-1)) - 1;
   localparam longint NEG_MIN = -(64'sd1 <<< (W-1));

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                in_valid = 1'b0;
   logic signed [W-1:0] in_left = '0, in_right = '0;
   logic                wr_en = 1'b0;
   logic [1:0]          wr_addr = '0;
   logic [8:0]          wr_data = '0;
   logic                out_valid;
   logic signed [W-1:0] out_left, out_right;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_out_stage u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
   );

   task automatic check(input string req, input longint act, input longint exp, input longint tol);
      longint diff;
      checks++;
      diff = act - exp;
      if (diff > tol || diff < -tol) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [8:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // drives one sample; returns at the negedge after the capturing edge
   task automatic send(input longint l, input longint r);
      @(negedge clk);
      in_valid = 1'b1; in_left = W'(l); in_right = W'(r);
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 valid", longint'(out_valid), 1, 0);
   endtask

   function automatic longint sat(input longint v);
      if (v > POS_MAX) return POS_MAX;
      if (v < NEG_MIN) return NEG_MIN;
      return v;
   endfunction

   function automatic longint model_gain(input longint s, input int code);
      int d, q, k, m;
      longint p;
      if (code == 0) return 0;
      d = code - 195;
      q = $rtoi($floor(d / 12.0));
      k = d - 12 * q;
      m = $rtoi(2.0 ** (k / 12.0) * 32768.0 + 0.5);
      p = s * m;
      return sat(p >>> (15 - q));
   endfunction

   function automatic longint neg_sat(input longint v);
      return sat(-v);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      longint sl [3];
      longint sr [3];
      sl[0] = 12345;   sr[0] = -54321;
      sl[1] = POS_MAX; sr[1] = NEG_MIN;
      sl[2] = -3;      sr[2] = 1000;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1 out_valid", longint'(out_valid), 0, 0);
      check("R1 out_left", longint'(out_left), 0, 0);
      check("R1 out_right", longint'(out_right), 0, 0);

      // R3 / R1: enables reset off
      send(5000, -7000);
      check("R3 disabled left", longint'(out_left), 0, 0);
      check("R3 disabled right", longint'(out_right), 0, 0);

      // R1 / R2: enable both, reset volume is unity
      wr(2'd0, 9'b0_0000_0011);
      send(5000, -7000);
      check("R1 unity left", longint'(out_left), 5000, 1);
      check("R1 unity right", longint'(out_right), -7000, 1);

      // R10: idle hold
      @(negedge clk);
      in_left = 24'sd777; in_right = 24'sd888;
      @(negedge clk);
      check("R10 idle valid", longint'(out_valid), 0, 0);
      check("R10 hold left", longint'(out_left), 5000, 1);
      check("R10 hold right", longint'(out_right), -7000, 1);

      // R4 / R5: all route and polarity codes
      for (int rt = 0; rt < 4; rt++) begin
         for (int pl = 0; pl < 4; pl++) begin
            longint el, er;
            wr(2'd0, 9'(rt * 16 + pl * 4 + 3));
            send(100000, -200000);
            el = (rt >= 2) ? -200000 : 100000;
            er = (rt % 2 == 1) ? 100000 : -200000;
            if (pl % 2 == 1) el = -el;
            if (pl >= 2) er = -er;
            check($sformatf("R4 R5 route%0d pol%0d left", rt, pl), longint'(out_left), el, 1);
            check($sformatf("R4 R5 route%0d pol%0d right", rt, pl), longint'(out_right), er, 1);
         end
      end

      // R3: only left ADC enabled, swap route
      wr(2'd0, 9'b0_0011_0001);
      send(4321, 9999);
      check("R3 swap disabled right src", longint'(out_left), 0, 0);
      check("R3 swap enabled left src", longint'(out_right), 4321, 1);

      // R5: negation of most negative
      wr(2'd0, 9'b0_0000_1111);
      send(NEG_MIN, NEG_MIN);
      check("R5 neg sat left", longint'(out_left), POS_MAX, 0);
      check("R5 neg sat right", longint'(out_right), POS_MAX, 0);

      // R2: address 3 ignored
      wr(2'd3, 9'h1FF);
      send(NEG_MIN, 300);
      check("R2 addr3 ignored left", longint'(out_left), POS_MAX, 0);
      check("R2 addr3 ignored right", longint'(out_right), -300, 1);

      // R6 / R7 / R9: sweep all codes
      wr(2'd0, 9'b0_0000_0011);
      for (int c = 0; c < 256; c++) begin
         wr(2'd1, 9'(c));
         wr(2'd2, 9'(256 + 255 - c));
         for (int i = 0; i < 3; i++) begin
            send(sl[i], sr[i]);
            check($sformatf("R6 R7 R9 left code%0d", c), longint'(out_left), model_gain(sl[i], c), 1);
            check($sformatf("R6 R7 R9 right code%0d", 255 - c), longint'(out_right), model_gain(sr[i], 255 - c), 1);
         end
      end

      // R9 explicit clamps at top gain
      wr(2'd1, 9'(256 + 255));
      wr(2'd2, 9'(256 + 255));
      send(400000, -400000);
      check("R9 clamp high", longint'(out_left), POS_MAX, 0);
      check("R9 clamp low", longint'(out_right), NEG_MIN, 0);

      // R7 mute
      wr(2'd1, 9'(256 + 0));
      send(POS_MAX, 1);
      check("R7 mute left", longint'(out_left), 0, 0);

      // R8: hold without commit, then paired commit
      wr(2'd1, 9'(256 + 195));
      wr(2'd2, 9'(256 + 195));
      wr(2'd1, 9'(150));
      wr(2'd2, 9'(100));
      send(1000, -1000);
      check("R8 no commit left", longint'(out_left), 1000, 1);
      check("R8 no commit right", longint'(out_right), -1000, 1);
      wr(2'd0, 9'b0_0000_0011);
      send(1000, -1000);
      check("R8 ctl write no commit left", longint'(out_left), 1000, 1);
      wr(2'd2, 9'(256 + 100));
      send(1000000, -1000000);
      check("R8 commit left", longint'(out_left), model_gain(1000000, 150), 1);
      check("R8 commit right", longint'(out_right), model_gain(-1000000, 100), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule